// File: doc/BRIEF.md
# Call, Return and Stack Sequencer

This unit carries out the control-transfer and stack instructions of an 8-bit processor with a 16-bit program counter. A decoder hands it an operation code together with its operands and the current PC, SP, PSW, AX and register-pair values. The unit then works through a fixed schedule of byte accesses on a single data-memory port. The operations covered are three call forms, a software break, three return forms, pushes, pops and stack-pointer moves. Every operation occupies a fixed number of clock cycles. In the last of these cycles the unit presents the updated register values, along with strobes that tell the surrounding core to clear its interrupt-enable flag or its non-maskable-in-service flag.

Requests arrive on a valid/ready channel. `req_ready` is high only while the unit is idle. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high, and the operands are captured on that edge. While `req_ready` is low, `req_valid` is neither stored nor queued, so the requester has to hold it until the unit is idle again. Results have no back-pressure: the result outputs are valid during the one-cycle `done` pulse and hold their values until the next request is taken. Memory reads return data in the cycle after the address is presented. Each cycle carries at most one access.

Top module: `stk_seq`

## Requirements
- R1: `req_ready` is low from the cycle after a request is taken up to and including the cycle of `done`. A `req_valid` seen in that window is ignored and does not change the running operation, its memory traffic or its results.
- R2: Cycle counts are measured with the accepting edge as edge 0, and `done` is high for exactly one cycle, cycle N. The `op_in` codes and their N values are: 0 long call 14, 1 short call 10, 2 table call 12, 3 break 12, 4 return 12, 5 interrupt return 12, 6 break return 12, 7 push PSW 4, 8 push pair 8, 9 pop PSW 4, 10 pop pair 8, 11 SP from immediate 20, 12 SP from AX 16, 13 AX from SP 16. Codes 14 and 15 take 4 cycles, change no register and make no access.
- R3: Long call (code 0) writes the high byte of PC+3 to SP-1 and the low byte to SP-2. It then sets PC to `addr16_in` and SP to SP-2.
- R4: Short call (code 1) writes PC+2 in the same byte order as R3 and sets SP to SP-2. It then sets PC to {5'b00001, `addr11_in`}.
- R5: Table call (code 2) writes PC+1 in the same byte order as R3 and sets SP to SP-2. It then loads the PC low byte from address {8'h00, `idx_in`} and the PC high byte from that address plus 1.
- R6: Break (code 3) writes PSW to SP-1, the high byte of PC+1 to SP-2 and the low byte to SP-3, and sets SP to SP-3. It loads the PC low byte from 16'h003E and the high byte from 16'h003F. `ie_clr` is high together with `done` and at no other time.
- R7: Return (code 4) loads the PC low byte from SP and the high byte from SP+1, sets SP to SP+2, and leaves PSW equal to `psw_in`.
- R8: Interrupt return (code 5) and break return (code 6) restore PC as in R7, load PSW from SP+2 and set SP to SP+3. `nmis_clr` is high together with `done` for code 5 only.
- R9: Push PSW (code 7) writes PSW to SP-1 and sets SP to SP-1. Push pair (code 8) writes the high byte of `rp_in` to SP-1 and the low byte to SP-2, and sets SP to SP-2.
- R10: Pop PSW (code 9) loads PSW from SP and sets SP to SP+1. Pop pair (code 10) loads the low byte of the pair from SP and the high byte from SP+1, and sets SP to SP+2.
- R11: Code 11 sets SP to `addr16_in`, code 12 sets SP to `ax_in`, and code 13 sets AX to `sp_in`.
- R12: All stack addresses and SP results wrap modulo 2^16.
- R13: `mem_en` is low whenever the unit is idle, `mem_we` is high only with `mem_en`, and the result outputs stay unchanged while idle.
- R14: After reset `req_ready` is high, `done`, `mem_en`, `ie_clr` and `nmis_clr` are low, and every result output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request will be taken |
| op_in | input | 4 | Operation code (R2) |
| addr16_in | input | 16 | Long-call target or immediate SP word |
| addr11_in | input | 11 | Short-call offset |
| idx_in | input | 5 | Table-call index |
| pc_in | input | 16 | PC of the instruction |
| sp_in | input | 16 | Current SP |
| psw_in | input | 8 | Current PSW |
| ax_in | input | 16 | Current AX |
| rp_in | input | 16 | Register pair to push |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Resulting PC |
| sp_out | output | 16 | Resulting SP |
| psw_out | output | 8 | Resulting PSW |
| ax_out | output | 16 | Resulting AX |
| rp_out | output | 16 | Resulting register pair |
| ie_clr | output | 1 | Clear interrupt enable, with `done` |
| nmis_clr | output | 1 | Clear NMI-in-service flag, with `done` |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after the address |

## Verification
A corrupted step counter shows up in two ways: `done` arrives in the wrong cycle, or an access goes to the wrong stack slot. Either one can be seen within the 4 to 20 cycles of a single instruction. A wrong read-destination tag or a dropped read return leaves the wrong byte in PC, PSW or the pair at `done`, and a wrong SP delta appears in `sp_out` at the same time. Because the sequence chains calls, pushes, pops and returns through one bench-held stack, a bad byte written to the stack also turns up one or more instructions later, as a wrong PC after a return or a wrong PSW after a pop.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int OP_W    = 4;
  localparam int IDX_W   = 5;
  localparam int SHORT_W = 11;
  localparam int PAGE_W  = WORD_W - SHORT_W;
  localparam int CNT_W   = 5;

  localparam logic [PAGE_W-1:0] SHORT_PAGE = 5'b00001;
  localparam logic [WORD_W-1:0] BRK_VEC    = 16'h003E;

  typedef enum logic [OP_W-1:0] {
    OP_CALL_LONG  = 4'd0,
    OP_CALL_SHORT = 4'd1,
    OP_CALL_TABLE = 4'd2,
    OP_BREAK      = 4'd3,
    OP_RET        = 4'd4,
    OP_RET_INT    = 4'd5,
    OP_RET_BRK    = 4'd6,
    OP_PUSH_PSW   = 4'd7,
    OP_PUSH_RP    = 4'd8,
    OP_POP_PSW    = 4'd9,
    OP_POP_RP     = 4'd10,
    OP_SP_IMM     = 4'd11,
    OP_SP_FROM_AX = 4'd12,
    OP_AX_FROM_SP = 4'd13,
    OP_NOP_E      = 4'd14,
    OP_NOP_F      = 4'd15
  } op_e;

  typedef enum logic [2:0] {
    DST_NONE, DST_PCL, DST_PCH, DST_PSW, DST_RPL, DST_RPH
  } dst_e;

  typedef struct packed {
    logic              en;
    logic              we;
    logic [WORD_W-1:0] addr;
    logic [BYTE_W-1:0] wdata;
    dst_e              dst;
  } acc_t;

  function automatic logic [CNT_W-1:0] op_cycles(input op_e op);
    case (op)
      OP_CALL_LONG:                  return CNT_W'(14);
      OP_CALL_SHORT:                 return CNT_W'(10);
      OP_CALL_TABLE, OP_BREAK,
      OP_RET, OP_RET_INT, OP_RET_BRK: return CNT_W'(12);
      OP_PUSH_RP, OP_POP_RP:         return CNT_W'(8);
      OP_SP_IMM:                     return CNT_W'(20);
      OP_SP_FROM_AX, OP_AX_FROM_SP:  return CNT_W'(16);
      default:                       return CNT_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/stk_cycle_ctr.sv
module stk_cycle_ctr
  import stk_seq_pkg::*;
#(
  parameter int STEP_W = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [STEP_W-1:0] ncyc,
  output logic              busy,
  output logic [STEP_W-1:0] step,
  output logic              done,
  output logic              fin
);
  logic [STEP_W-1:0] lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= '0;
      lim  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      step <= STEP_W'(1);
      lim  <= ncyc;
    end else if (busy) begin
      if (step == lim) begin
        busy <= 1'b0;
        step <= '0;
      end else begin
        step <= step + STEP_W'(1);
      end
    end
  end

  assign done = busy && (step == lim);
  assign fin  = busy && (step == lim - STEP_W'(1));

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R1
endmodule

// File: rtl/stk_step_plan.sv
module stk_step_plan
  import stk_seq_pkg::*;
#(
  parameter int STEP_W = CNT_W
) (
  input  logic              busy,
  input  op_e               op,
  input  logic [STEP_W-1:0] step,
  input  logic [WORD_W-1:0] pc,
  input  logic [WORD_W-1:0] sp,
  input  logic [BYTE_W-1:0] psw,
  input  logic [WORD_W-1:0] rp,
  input  logic [IDX_W-1:0]  idx,
  output acc_t              acc
);
  logic [WORD_W-1:0] ra;
  logic [WORD_W-1:0] tbl;

  always_comb begin
    case (op)
      OP_CALL_LONG:  ra = pc + WORD_W'(3);
      OP_CALL_SHORT: ra = pc + WORD_W'(2);
      default:       ra = pc + WORD_W'(1);
    endcase
    tbl = {{(WORD_W-IDX_W){1'b0}}, idx};
  end

  function automatic acc_t wr(input logic [WORD_W-1:0] a, input logic [BYTE_W-1:0] d);
    return '{en: 1'b1, we: 1'b1, addr: a, wdata: d, dst: DST_NONE};
  endfunction

  function automatic acc_t rd(input logic [WORD_W-1:0] a, input dst_e d);
    return '{en: 1'b1, we: 1'b0, addr: a, wdata: '0, dst: d};
  endfunction

  always_comb begin
    acc = '{en: 1'b0, we: 1'b0, addr: '0, wdata: '0, dst: DST_NONE};
    if (busy) begin
      case (op)
        OP_CALL_LONG, OP_CALL_SHORT, OP_CALL_TABLE: begin
          case (step)
            STEP_W'(1): acc = wr(sp - WORD_W'(1), ra[WORD_W-1:BYTE_W]);
            STEP_W'(2): acc = wr(sp - WORD_W'(2), ra[BYTE_W-1:0]);
            STEP_W'(3): if (op == OP_CALL_TABLE) acc = rd(tbl, DST_PCL);
            STEP_W'(4): if (op == OP_CALL_TABLE) acc = rd(tbl + WORD_W'(1), DST_PCH);
            default: ;
          endcase
        end
        OP_BREAK: begin
          case (step)
            STEP_W'(1): acc = wr(sp - WORD_W'(1), psw);
            STEP_W'(2): acc = wr(sp - WORD_W'(2), ra[WORD_W-1:BYTE_W]);
            STEP_W'(3): acc = wr(sp - WORD_W'(3), ra[BYTE_W-1:0]);
            STEP_W'(4): acc = rd(BRK_VEC, DST_PCL);
            STEP_W'(5): acc = rd(BRK_VEC + WORD_W'(1), DST_PCH);
            default: ;
          endcase
        end
        OP_RET, OP_RET_INT, OP_RET_BRK: begin
          case (step)
            STEP_W'(1): acc = rd(sp, DST_PCL);
            STEP_W'(2): acc = rd(sp + WORD_W'(1), DST_PCH);
            STEP_W'(3): if (op != OP_RET) acc = rd(sp + WORD_W'(2), DST_PSW);
            default: ;
          endcase
        end
        OP_PUSH_PSW: if (step == STEP_W'(1)) acc = wr(sp - WORD_W'(1), psw);
        OP_PUSH_RP: begin
          case (step)
            STEP_W'(1): acc = wr(sp - WORD_W'(1), rp[WORD_W-1:BYTE_W]);
            STEP_W'(2): acc = wr(sp - WORD_W'(2), rp[BYTE_W-1:0]);
            default: ;
          endcase
        end
        OP_POP_PSW: if (step == STEP_W'(1)) acc = rd(sp, DST_PSW);
        OP_POP_RP: begin
          case (step)
            STEP_W'(1): acc = rd(sp, DST_RPL);
            STEP_W'(2): acc = rd(sp + WORD_W'(1), DST_RPH);
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/stk_work_regs.sv
module stk_work_regs
  import stk_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [WORD_W-1:0]  pc_in,
  input  logic [WORD_W-1:0]  sp_in,
  input  logic [BYTE_W-1:0]  psw_in,
  input  logic [WORD_W-1:0]  ax_in,
  input  logic [WORD_W-1:0]  rp_in,
  input  op_e                op,
  input  logic [WORD_W-1:0]  a16,
  input  logic [SHORT_W-1:0] a11,
  input  logic               ret_en,
  input  dst_e               ret_dst,
  input  logic [BYTE_W-1:0]  ret_data,
  input  logic               fin,
  output logic [WORD_W-1:0]  pc,
  output logic [WORD_W-1:0]  sp,
  output logic [BYTE_W-1:0]  psw,
  output logic [WORD_W-1:0]  ax,
  output logic [WORD_W-1:0]  rp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc  <= '0;
      sp  <= '0;
      psw <= '0;
      ax  <= '0;
      rp  <= '0;
    end else if (load) begin
      pc  <= pc_in;
      sp  <= sp_in;
      psw <= psw_in;
      ax  <= ax_in;
      rp  <= rp_in;
    end else begin
      if (ret_en) begin
        case (ret_dst)
          DST_PCL: pc[BYTE_W-1:0]      <= ret_data;
          DST_PCH: pc[WORD_W-1:BYTE_W] <= ret_data;
          DST_PSW: psw                 <= ret_data;
          DST_RPL: rp[BYTE_W-1:0]      <= ret_data;
          DST_RPH: rp[WORD_W-1:BYTE_W] <= ret_data;
          default: ;
        endcase
      end
      if (fin) begin
        case (op)
          OP_CALL_LONG: begin
            pc <= a16;
            sp <= sp - WORD_W'(2);
          end
          OP_CALL_SHORT: begin
            pc <= {SHORT_PAGE, a11};
            sp <= sp - WORD_W'(2);
          end
          OP_CALL_TABLE, OP_PUSH_RP: sp <= sp - WORD_W'(2);
          OP_BREAK:                  sp <= sp - WORD_W'(3);
          OP_RET, OP_POP_RP:         sp <= sp + WORD_W'(2);
          OP_RET_INT, OP_RET_BRK:    sp <= sp + WORD_W'(3);
          OP_PUSH_PSW:               sp <= sp - WORD_W'(1);
          OP_POP_PSW:                sp <= sp + WORD_W'(1);
          OP_SP_IMM:                 sp <= a16;
          OP_SP_FROM_AX:             sp <= ax;
          OP_AX_FROM_SP:             ax <= sp;
          default: ;
        endcase
      end
    end
  end

  AST_NO_RET_AT_FIN: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> !(ret_en && (ret_dst == DST_PCL || ret_dst == DST_PCH))); // R5
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [OP_W-1:0]    op_in,
  input  logic [WORD_W-1:0]  addr16_in,
  input  logic [SHORT_W-1:0] addr11_in,
  input  logic [IDX_W-1:0]   idx_in,
  input  logic [WORD_W-1:0]  pc_in,
  input  logic [WORD_W-1:0]  sp_in,
  input  logic [BYTE_W-1:0]  psw_in,
  input  logic [WORD_W-1:0]  ax_in,
  input  logic [WORD_W-1:0]  rp_in,
  output logic               done,
  output logic [WORD_W-1:0]  pc_out,
  output logic [WORD_W-1:0]  sp_out,
  output logic [BYTE_W-1:0]  psw_out,
  output logic [WORD_W-1:0]  ax_out,
  output logic [WORD_W-1:0]  rp_out,
  output logic               ie_clr,
  output logic               nmis_clr,
  output logic               mem_en,
  output logic               mem_we,
  output logic [WORD_W-1:0]  mem_addr,
  output logic [BYTE_W-1:0]  mem_wdata,
  input  logic [BYTE_W-1:0]  mem_rdata
);
  logic               busy, fin, accept;
  logic [CNT_W-1:0]   step;
  op_e                op_r;
  logic [WORD_W-1:0]  a16_r;
  logic [SHORT_W-1:0] a11_r;
  logic [IDX_W-1:0]   idx_r;
  acc_t               acc;
  logic               rd_pend;
  dst_e               rd_dst;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_r  <= OP_CALL_LONG;
      a16_r <= '0;
      a11_r <= '0;
      idx_r <= '0;
    end else if (accept) begin
      op_r  <= op_e'(op_in);
      a16_r <= addr16_in;
      a11_r <= addr11_in;
      idx_r <= idx_in;
    end
  end

  stk_cycle_ctr #(.STEP_W(CNT_W)) u_ctr (
    .clk  (clk),
    .rst_n(rst_n),
    .start(accept),
    .ncyc (op_cycles(op_e'(op_in))),
    .busy (busy),
    .step (step),
    .done (done),
    .fin  (fin)
  );

  stk_step_plan #(.STEP_W(CNT_W)) u_plan (
    .busy(busy),
    .op  (op_r),
    .step(step),
    .pc  (pc_out),
    .sp  (sp_out),
    .psw (psw_out),
    .rp  (rp_out),
    .idx (idx_r),
    .acc (acc)
  );

  assign mem_en    = acc.en;
  assign mem_we    = acc.en && acc.we;
  assign mem_addr  = acc.addr;
  assign mem_wdata = acc.wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      rd_dst  <= DST_NONE;
    end else begin
      rd_pend <= acc.en && !acc.we;
      rd_dst  <= acc.dst;
    end
  end

  stk_work_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .pc_in   (pc_in),
    .sp_in   (sp_in),
    .psw_in  (psw_in),
    .ax_in   (ax_in),
    .rp_in   (rp_in),
    .op      (op_r),
    .a16     (a16_r),
    .a11     (a11_r),
    .ret_en  (rd_pend),
    .ret_dst (rd_dst),
    .ret_data(mem_rdata),
    .fin     (fin),
    .pc      (pc_out),
    .sp      (sp_out),
    .psw     (psw_out),
    .ax      (ax_out),
    .rp      (rp_out)
  );

  assign ie_clr   = done && (op_r == OP_BREAK);
  assign nmis_clr = done && (op_r == OP_RET_INT);

  AST_MEM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_en); // R13
  AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en); // R13
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> ($stable(sp_out) && $stable(pc_out) && $stable(psw_out))); // R13
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R1
  AST_IE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ie_clr |-> done); // R6
  AST_NMIS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    nmis_clr |-> (done && !ie_clr)); // R8
  AST_RET_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |-> busy); // R13
endmodule

// File: tb/stk_seq_tb.sv
module stk_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 20;
  localparam int MEMN = 1024;

  typedef struct packed {
    logic [3:0]  op;
    logic [15:0] a16;
    logic [10:0] a11;
    logic [4:0]  idx;
    logic [15:0] pc;
    logic [7:0]  psw;
    logic [15:0] ax;
    logic [15:0] rp;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{4'd11, 16'hFE20, 11'h000, 5'h00, 16'h0100, 8'h00, 16'h0000, 16'h0000},
    '{4'd0,  16'h4000, 11'h000, 5'h00, 16'h1234, 8'h11, 16'h0000, 16'h0000},
    '{4'd1,  16'h0000, 11'h155, 5'h00, 16'h4000, 8'h22, 16'h0000, 16'h0000},
    '{4'd8,  16'h0000, 11'h000, 5'h00, 16'h0955, 8'h33, 16'h0000, 16'hBEEF},
    '{4'd7,  16'h0000, 11'h000, 5'h00, 16'h0956, 8'hA5, 16'h0000, 16'h0000},
    '{4'd9,  16'h0000, 11'h000, 5'h00, 16'h0957, 8'h00, 16'h0000, 16'h0000},
    '{4'd10, 16'h0000, 11'h000, 5'h00, 16'h0958, 8'hA5, 16'h0000, 16'h0000},
    '{4'd4,  16'h0000, 11'h000, 5'h00, 16'h0959, 8'hA5, 16'h0000, 16'h0000},
    '{4'd4,  16'h0000, 11'h000, 5'h00, 16'h4002, 8'h66, 16'h0000, 16'h0000},
    '{4'd3,  16'h0000, 11'h000, 5'h00, 16'h2000, 8'h5A, 16'h0000, 16'h0000},
    '{4'd6,  16'h0000, 11'h000, 5'h00, 16'h1280, 8'h00, 16'h0000, 16'h0000},
    '{4'd2,  16'h0000, 11'h000, 5'h10, 16'h3000, 8'h77, 16'h0000, 16'h0000},
    '{4'd4,  16'h0000, 11'h000, 5'h00, 16'h5000, 8'h77, 16'h0000, 16'h0000},
    '{4'd3,  16'h0000, 11'h000, 5'h00, 16'h6000, 8'h44, 16'h0000, 16'h0000},
    '{4'd5,  16'h0000, 11'h000, 5'h00, 16'h1280, 8'h00, 16'h0000, 16'h0000},
    '{4'd12, 16'h0000, 11'h000, 5'h00, 16'h6001, 8'h44, 16'h0001, 16'h0000},
    '{4'd8,  16'h0000, 11'h000, 5'h00, 16'h6002, 8'h44, 16'h0001, 16'h1122},
    '{4'd10, 16'h0000, 11'h000, 5'h00, 16'h6003, 8'h44, 16'h0001, 16'h0000},
    '{4'd13, 16'h0000, 11'h000, 5'h00, 16'h6004, 8'h44, 16'h9999, 16'h0000},
    '{4'd14, 16'h0000, 11'h000, 5'h00, 16'h7777, 8'h3C, 16'h5555, 16'hAAAA}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  op_in = '0;
  logic [15:0] addr16_in = '0;
  logic [10:0] addr11_in = '0;
  logic [4:0]  idx_in = '0;
  logic [15:0] pc_in = '0, sp_in = '0, ax_in = '0, rp_in = '0;
  logic [7:0]  psw_in = '0;
  logic        done, ie_clr, nmis_clr, mem_en, mem_we;
  logic [15:0] pc_out, sp_out, ax_out, rp_out, mem_addr;
  logic [7:0]  psw_out, mem_wdata;
  logic [7:0]  mem_rdata;

  logic [7:0]  dut_mem [MEMN];
  logic [7:0]  ref_mem [MEMN];
  logic [7:0]  rd_q;
  int          wr_total;
  int          idle_acc;
  int          checks = 0;
  int          fails = 0;

  logic [15:0] cur_sp = '0;
  logic [15:0] e_pc, e_sp, e_ax, e_rp;
  logic [7:0]  e_psw;
  logic        e_ie, e_nm;
  int          e_cyc, ew_n;
  logic [15:0] ew_addr [3];
  logic [7:0]  ew_data [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  stk_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .op_in(op_in), .addr16_in(addr16_in), .addr11_in(addr11_in), .idx_in(idx_in),
    .pc_in(pc_in), .sp_in(sp_in), .psw_in(psw_in), .ax_in(ax_in), .rp_in(rp_in),
    .done(done), .pc_out(pc_out), .sp_out(sp_out), .psw_out(psw_out),
    .ax_out(ax_out), .rp_out(rp_out), .ie_clr(ie_clr), .nmis_clr(nmis_clr),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  assign mem_rdata = rd_q;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEMN; i++) dut_mem[i] <= 8'h00;
      dut_mem[10'h03E] <= 8'h80;
      dut_mem[10'h03F] <= 8'h12;
      dut_mem[10'h010] <= 8'h00;
      dut_mem[10'h011] <= 8'h50;
      rd_q     <= 8'h00;
      wr_total <= 0;
      idle_acc <= 0;
    end else begin
      if (mem_en) begin
        if (mem_we) begin
          dut_mem[mem_addr[9:0]] <= mem_wdata;
          wr_total <= wr_total + 1;
        end else begin
          rd_q <= dut_mem[mem_addr[9:0]];
        end
      end
      if (mem_en && req_ready) idle_acc <= idle_acc + 1;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3: return "R6";
      4'd4: return "R7";
      4'd5, 4'd6: return "R8";
      4'd7, 4'd8: return "R9";
      4'd9, 4'd10: return "R10";
      4'd11, 4'd12, 4'd13: return "R11";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [7:0] rm(input logic [15:0] a);
    return ref_mem[a[9:0]];
  endfunction

  task automatic rw(input logic [15:0] a, input logic [7:0] d);
    ew_addr[ew_n] = a;
    ew_data[ew_n] = d;
    ew_n++;
    ref_mem[a[9:0]] = d;
  endtask

  task automatic ref_exec(input vec_t v);
    logic [15:0] ra;
    e_pc = v.pc; e_sp = cur_sp; e_psw = v.psw; e_ax = v.ax; e_rp = v.rp;
    e_ie = 1'b0; e_nm = 1'b0; ew_n = 0; e_cyc = 4;
    case (v.op)
      4'd0, 4'd1, 4'd2: begin
        ra = v.pc + ((v.op == 4'd0) ? 16'd3 : (v.op == 4'd1) ? 16'd2 : 16'd1);
        rw(e_sp - 16'd1, ra[15:8]);
        rw(e_sp - 16'd2, ra[7:0]);
        e_sp = e_sp - 16'd2;
        if (v.op == 4'd0) begin e_pc = v.a16; e_cyc = 14; end
        else if (v.op == 4'd1) begin e_pc = {5'b00001, v.a11}; e_cyc = 10; end
        else begin
          e_pc = {rm({11'd0, v.idx} + 16'd1), rm({11'd0, v.idx})};
          e_cyc = 12;
        end
      end
      4'd3: begin
        ra = v.pc + 16'd1;
        rw(e_sp - 16'd1, v.psw);
        rw(e_sp - 16'd2, ra[15:8]);
        rw(e_sp - 16'd3, ra[7:0]);
        e_sp = e_sp - 16'd3;
        e_pc = {rm(16'h003F), rm(16'h003E)};
        e_ie = 1'b1; e_cyc = 12;
      end
      4'd4: begin
        e_pc = {rm(e_sp + 16'd1), rm(e_sp)};
        e_sp = e_sp + 16'd2; e_cyc = 12;
      end
      4'd5, 4'd6: begin
        e_pc = {rm(e_sp + 16'd1), rm(e_sp)};
        e_psw = rm(e_sp + 16'd2);
        e_sp = e_sp + 16'd3; e_cyc = 12;
        e_nm = (v.op == 4'd5);
      end
      4'd7: begin rw(e_sp - 16'd1, v.psw); e_sp = e_sp - 16'd1; e_cyc = 4; end
      4'd8: begin
        rw(e_sp - 16'd1, v.rp[15:8]);
        rw(e_sp - 16'd2, v.rp[7:0]);
        e_sp = e_sp - 16'd2; e_cyc = 8;
      end
      4'd9: begin e_psw = rm(e_sp); e_sp = e_sp + 16'd1; e_cyc = 4; end
      4'd10: begin
        e_rp = {rm(e_sp + 16'd1), rm(e_sp)};
        e_sp = e_sp + 16'd2; e_cyc = 8;
      end
      4'd11: begin e_sp = v.a16; e_cyc = 20; end
      4'd12: begin e_sp = v.ax; e_cyc = 16; end
      4'd13: begin e_ax = e_sp; e_cyc = 16; end
      default: e_cyc = 4;
    endcase
  endtask

  task automatic drive(input vec_t v);
    op_in = v.op; addr16_in = v.a16; addr11_in = v.a11; idx_in = v.idx;
    pc_in = v.pc; sp_in = cur_sp; psw_in = v.psw; ax_in = v.ax; rp_in = v.rp;
  endtask

  task automatic run_vec(input vec_t v);
    int n;
    int w0;
    string rq;
    rq = req_of(v.op);
    ref_exec(v);
    @(negedge clk);
    drive(v);
    w0 = wr_total;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    while (!done && n < 64) begin
      @(negedge clk);
      n++;
    end
    chk("R2", "cycles", 32'(n), 32'(e_cyc));
    chk(rq, "pc", {16'd0, pc_out}, {16'd0, e_pc});
    chk((v.op == 4'd1 || v.op == 4'd2 || v.op == 4'd8 || v.op == 4'd10) && cur_sp < 16'd4 ? "R12" : rq,
        "sp", {16'd0, sp_out}, {16'd0, e_sp});
    chk(rq, "psw", {24'd0, psw_out}, {24'd0, e_psw});
    chk(rq, "ax", {16'd0, ax_out}, {16'd0, e_ax});
    chk(rq, "rp", {16'd0, rp_out}, {16'd0, e_rp});
    chk("R6", "ie_clr", {31'd0, ie_clr}, {31'd0, e_ie});
    chk("R8", "nmis_clr", {31'd0, nmis_clr}, {31'd0, e_nm});
    @(negedge clk);
    chk("R2", "done width", {31'd0, done}, 32'd0);
    chk(rq, "write count", 32'(wr_total - w0), 32'(ew_n));
    for (int j = 0; j < ew_n; j++)
      chk(rq, "stack byte", {16'd0, dut_mem[ew_addr[j][9:0]], 8'd0},
          {16'd0, ew_data[j], 8'd0});
    cur_sp = e_sp;
  endtask

  initial begin
    for (int i = 0; i < MEMN; i++) ref_mem[i] = 8'h00;
    ref_mem[10'h03E] = 8'h80;
    ref_mem[10'h03F] = 8'h12;
    ref_mem[10'h010] = 8'h00;
    ref_mem[10'h011] = 8'h50;
    repeat (4) @(negedge clk);
    // R14 reset state
    chk("R14", "ready in reset", {31'd0, req_ready}, 32'd1);
    chk("R14", "done in reset", {31'd0, done}, 32'd0);
    chk("R14", "mem_en in reset", {31'd0, mem_en}, 32'd0);
    chk("R14", "clr strobes in reset", {30'd0, ie_clr, nmis_clr}, 32'd0);
    chk("R14", "pc/sp in reset", {pc_out, sp_out}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R14", "ready after reset", {31'd0, req_ready}, 32'd1);

    for (int k = 0; k < NVEC; k++) run_vec(VECS[k]);

    // R1: request during busy ignored; cur_sp is 0x0001 here, so R12 wrap as well
    begin
      vec_t pv;
      int n;
      int w0;
      pv = '{4'd8, 16'h0000, 11'h000, 5'h00, 16'h0000, 8'h00, 16'h0000, 16'h7788};
      ref_exec(pv);
      @(negedge clk);
      drive(pv);
      w0 = wr_total;
      req_valid = 1'b1;
      @(negedge clk);
      op_in = 4'd11; addr16_in = 16'h1111;
      n = 1;
      @(negedge clk); n++;
      chk("R1", "ready while busy", {31'd0, req_ready}, 32'd0);
      @(negedge clk); n++;
      req_valid = 1'b0;
      while (!done && n < 64) begin
        @(negedge clk);
        n++;
      end
      chk("R1", "cycles with ignored request", 32'(n), 32'd8);
      chk("R1", "sp not taken from ignored request", {16'd0, sp_out}, {16'd0, e_sp});
      chk("R12", "wrapped sp", {16'd0, sp_out}, 32'h0000FFFF);
      chk("R12", "byte at 0xFFFF", {24'd0, dut_mem[10'h3FF]}, 32'h88);
      @(negedge clk);
      chk("R1", "writes with ignored request", 32'(wr_total - w0), 32'd2);
      chk("R1", "no restart", {31'd0, req_ready}, 32'd1);
      cur_sp = e_sp;
    end

    // R13: outputs hold while idle, no idle accesses
    repeat (5) @(negedge clk);
    chk("R13", "sp held idle", {16'd0, sp_out}, 32'h0000FFFF);
    chk("R13", "rp held idle", {16'd0, rp_out}, 32'h00007788);
    chk("R13", "done low idle", {31'd0, done}, 32'd0);
    chk("R13", "no access while idle", 32'(idle_acc), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule